// File: doc/BRIEF.md
# Noise and Interference Weighting Mixer

This block builds the disturbance stream for a second DAC channel. It reads a stored noise record through an address port. Each playback pass begins at a pseudo-random position in that record. Every noise sample is scaled by a noise weight.

When the interference path is switched on, samples from a second stored record are also scaled, by their own weight, and added to the scaled noise. The result is clipped to a signed 14-bit DAC word. One word is produced for each pulse of the sample strobe, which runs at the same rate as the main communication waveform.

Both weights can be rewritten while the block runs, through a small register-write port. A new weight waits in a holding register and is applied only on a sample boundary.

Top module: `noise_mixer`

## Requirements
- R1: After synchronous reset, `dac_word` is 0 and `dac_stb` is 0. Both buffer addresses are 0, the block is idle, and both the pending and the active weights equal 0x8000.
- R2: A 16-bit shift register runs on every clock after reset. It starts at 0xACE1 and each step shifts it left, feeding bit 0 with b15^b13^b12^b10. When `start_cmd` is sampled high, `noise_addr` is loaded with the register value present at that edge modulo NOISE_DEPTH. At the same edge `intf_addr` is loaded with 0 and the block enters the running state.
- R3: A sample is taken on any edge where `smp_tick` is high, the block is running and `start_cmd` is low. On the following cycle `dac_word` holds the mixed result for the samples at the current addresses, and `dac_stb` is high for exactly that one cycle.
- R4: Weights are unsigned Q1.15, where 0x8000 means 1.0. The noise term is floor(noise_sample * noise_weight / 32768).
- R5: With `intf_en` high, the term floor(intf_sample * intf_weight / 32768) is added to the noise term.
- R6: With `intf_en` low, the interference term is zero and `intf_addr` does not move.
- R7: The sum is saturated to the range -8192..8191 and does not wrap.
- R8: Each sample advances `noise_addr` by one, wrapping from NOISE_DEPTH-1 to 0. When interference is on, `intf_addr` advances in the same way with INTF_DEPTH. Outside samples and start commands, the addresses do not change.
- R9: A write with `wr_sel`=0 sets the pending noise weight, and `wr_sel`=1 sets the pending interference weight. At every `smp_tick` edge, the pending weights become active. The sample computed at that same edge still uses the previously active weights. When several writes come between ticks, the last one wins.
- R10: `stop_cmd` returns the block to idle. A tick while idle sets `dac_word` to 0, keeps `dac_stb` low and leaves the addresses unchanged.
- R11: When `start_cmd` and `smp_tick` are high together, the start wins. No sample is produced, `dac_word` becomes 0, and a start while running reloads both addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | Sample strobe, one cycle per output sample |
| start_cmd | input | 1 | Begin a pass at a random noise address |
| stop_cmd | input | 1 | End playback |
| intf_en | input | 1 | Include the interference term |
| wr_en | input | 1 | Weight write strobe |
| wr_sel | input | 1 | 0 selects the noise weight, 1 selects the interference weight |
| wr_gain | input | 16 | Unsigned Q1.15 weight value |
| noise_addr | output | clog2(NOISE_DEPTH) | Noise buffer read address |
| noise_rd | input | 14 | Signed noise sample at `noise_addr` |
| intf_addr | output | clog2(INTF_DEPTH) | Interference buffer read address |
| intf_rd | input | 14 | Signed interference sample at `intf_addr` |
| dac_word | output | 14 | Signed mixed DAC word |
| dac_stb | output | 1 | High for the cycle that follows a sample |

## Verification
Buffer reads are combinational. The mixed word, the strobe and the advanced addresses therefore all appear one clock after the edge that sampled `smp_tick` or `start_cmd`. The bench drives each stimulus on a falling edge and checks at the next falling edge, so it looks at exactly that one register stage.

Weight writes take one more sample to show. The bench's reference moves pending weights to active only after it has computed the word for the current tick, which matches that second stage. The start address is predicted from a reference shift register clocked on the same rising edges, read just before the start edge.

// File: rtl/nmix_pkg.sv
package nmix_pkg;

    localparam int SMP_W  = 14;
    localparam int GAIN_W = 16;
    localparam int LFSR_W = 16;

    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [SMP_W:0]   term_t;
    typedef logic signed [SMP_W+1:0] acc_t;
    typedef logic [GAIN_W-1:0]       gain_t;

    localparam gain_t GAIN_UNITY = gain_t'(1 << (GAIN_W - 1));

    typedef enum logic {
        GSEL_NOISE = 1'b0,
        GSEL_INTF  = 1'b1
    } gsel_e;

    typedef struct packed {
        gain_t noise;
        gain_t intf;
    } gain_pair_t;

    // Fibonacci step: taps 16,14,13,11
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Signed sample times unsigned Q1.15 weight, floored back to SMP_W+1 bits
    function automatic term_t scale_term(input smp_t s, input gain_t g);
        logic signed [SMP_W+GAIN_W:0] prod;
        prod = $signed({{(GAIN_W+1){s[SMP_W-1]}}, s}) *
               $signed({{SMP_W{1'b0}}, 1'b0, g});
        return term_t'(prod >>> (GAIN_W - 1));
    endfunction

    function automatic acc_t add_terms(input term_t a, input term_t b);
        return acc_t'({a[SMP_W], a}) + acc_t'({b[SMP_W], b});
    endfunction

    function automatic smp_t clip_sample(input acc_t x);
        acc_t hi;
        acc_t lo;
        hi = acc_t'((1 << (SMP_W - 1)) - 1);
        lo = -hi - acc_t'(1);
        if (x > hi)      return smp_t'(hi);
        else if (x < lo) return smp_t'(lo);
        else             return smp_t'(x);
    endfunction

endpackage

// File: rtl/start_lfsr.sv
module start_lfsr
    import nmix_pkg::*;
#(
    parameter int DEPTH = 1000,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] start_addr
);

    logic [LFSR_W-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= LFSR_SEED;
        else     lfsr_q <= lfsr_next(lfsr_q);
    end

    always_comb start_addr = AW'(lfsr_q % LFSR_W'(DEPTH));

    // R2
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

endmodule

// File: rtl/addr_ring.sv
module addr_ring #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst)       addr_q <= '0;
        else if (load) addr_q <= load_val;
        else if (step) addr_q <= (addr_q == LAST) ? '0 : addr_q + AW'(1);
    end

    assign addr = addr_q;

    // R8
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        addr_q <= LAST);

endmodule

// File: rtl/gain_shadow.sv
module gain_shadow
    import nmix_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  gsel_e      wr_sel,
    input  gain_t      wr_gain,
    input  logic       commit,
    output gain_pair_t active
);

    gain_pair_t pend_q;
    gain_pair_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '{noise: GAIN_UNITY, intf: GAIN_UNITY};
        end else if (wr_en) begin
            case (wr_sel)
                GSEL_NOISE: pend_q.noise <= wr_gain;
                GSEL_INTF:  pend_q.intf  <= wr_gain;
                default:    pend_q       <= pend_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         act_q <= '{noise: GAIN_UNITY, intf: GAIN_UNITY};
        else if (commit) act_q <= pend_q;
    end

    assign active = act_q;

    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    // R9
    gain_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !commit |=> $stable(act_q));

endmodule

// File: rtl/weight_mac.sv
module weight_mac
    import nmix_pkg::*;
(
    input  smp_t       noise_s,
    input  smp_t       intf_s,
    input  gain_pair_t gains,
    input  logic       intf_on,
    output smp_t       mixed
);

    term_t n_term;
    term_t i_term;
    acc_t  total;

    always_comb begin
        n_term = scale_term(noise_s, gains.noise);
        i_term = intf_on ? scale_term(intf_s, gains.intf) : '0;
        total  = add_terms(n_term, i_term);
        mixed  = clip_sample(total);
    end

endmodule

// File: rtl/noise_mixer.sv
module noise_mixer
    import nmix_pkg::*;
#(
    parameter int NOISE_DEPTH = 1000,
    parameter int INTF_DEPTH  = 12,
    localparam int NAW = (NOISE_DEPTH > 1) ? $clog2(NOISE_DEPTH) : 1,
    localparam int IAW = (INTF_DEPTH > 1) ? $clog2(INTF_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_tick,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic             intf_en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [15:0]      wr_gain,
    output logic [NAW-1:0]   noise_addr,
    input  logic [13:0]      noise_rd,
    output logic [IAW-1:0]   intf_addr,
    input  logic [13:0]      intf_rd,
    output logic [13:0]      dac_word,
    output logic             dac_stb
);

    logic       run_q;
    logic       fire;
    logic [NAW-1:0] rand_addr;
    gain_pair_t gains;
    smp_t       mixed;
    smp_t       dac_q;
    logic       stb_q;

    assign fire = smp_tick && run_q && !start_cmd;

    start_lfsr #(.DEPTH(NOISE_DEPTH)) u_seed (
        .clk        (clk),
        .rst        (rst),
        .start_addr (rand_addr)
    );

    addr_ring #(.DEPTH(NOISE_DEPTH)) u_noise_ring (
        .clk      (clk),
        .rst      (rst),
        .load     (start_cmd),
        .load_val (rand_addr),
        .step     (fire),
        .addr     (noise_addr)
    );

    addr_ring #(.DEPTH(INTF_DEPTH)) u_intf_ring (
        .clk      (clk),
        .rst      (rst),
        .load     (start_cmd),
        .load_val ('0),
        .step     (fire && intf_en),
        .addr     (intf_addr)
    );

    gain_shadow u_gains (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (gsel_e'(wr_sel)),
        .wr_gain (gain_t'(wr_gain)),
        .commit  (smp_tick),
        .active  (gains)
    );

    weight_mac u_mac (
        .noise_s (smp_t'(noise_rd)),
        .intf_s  (smp_t'(intf_rd)),
        .gains   (gains),
        .intf_on (intf_en),
        .mixed   (mixed)
    );

    always_ff @(posedge clk) begin
        if (rst)            run_q <= 1'b0;
        else if (start_cmd) run_q <= 1'b1;
        else if (stop_cmd)  run_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q <= '0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= fire;
            if (fire)          dac_q <= mixed;
            else if (smp_tick) dac_q <= '0;
        end
    end

    assign dac_word = dac_q;
    assign dac_stb  = stb_q;

    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    // R3
    stb_cause_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        dac_stb |-> ($past(smp_tick) && $past(run_q) && !$past(start_cmd)));

    // R6
    intf_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (!intf_en && !start_cmd) |=> $stable(intf_addr));

    // R8
    noise_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (!smp_tick && !start_cmd) |=> $stable(noise_addr));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ($past(smp_tick) && !dac_stb) |-> (dac_word == '0));

endmodule

// File: tb/tb_noise_mixer.sv
module tb_noise_mixer;

    localparam int CLK_PERIOD = 10;
    localparam int ND  = 1000;
    localparam int ID  = 12;
    localparam int NAW = $clog2(ND);
    localparam int IAW = $clog2(ID);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_tick = 1'b0, start_cmd = 1'b0, stop_cmd = 1'b0, intf_en = 1'b0;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [15:0] wr_gain = '0;
    logic [NAW-1:0] noise_addr;
    logic [IAW-1:0] intf_addr;
    logic [13:0] noise_rd, intf_rd, dac_word;
    logic dac_stb;

    always #(CLK_PERIOD/2) clk = ~clk;

    noise_mixer #(.NOISE_DEPTH(ND), .INTF_DEPTH(ID)) dut (
        .clk(clk), .rst(rst), .smp_tick(smp_tick), .start_cmd(start_cmd),
        .stop_cmd(stop_cmd), .intf_en(intf_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_gain(wr_gain), .noise_addr(noise_addr), .noise_rd(noise_rd),
        .intf_addr(intf_addr), .intf_rd(intf_rd), .dac_word(dac_word),
        .dac_stb(dac_stb)
    );

    function automatic int noise_val(input int a);
        return ((a * 1237 + 311) % 16384) - 8192;
    endfunction
    function automatic int intf_val(input int a);
        return ((a * 2909 + 77) % 16384) - 8192;
    endfunction

    assign noise_rd = 14'(noise_val(int'(noise_addr)));
    assign intf_rd  = 14'(intf_val(int'(intf_addr)));

    // reference shift register (R2)
    logic [15:0] ref_lfsr;
    always @(posedge clk) begin
        if (rst) ref_lfsr <= 16'hACE1;
        else     ref_lfsr <= {ref_lfsr[14:0], ref_lfsr[15] ^ ref_lfsr[13] ^ ref_lfsr[12] ^ ref_lfsr[10]};
    end

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;
    int m_naddr = 0, m_iaddr = 0, m_out = 0;
    bit m_run = 1'b0;
    int m_pend_n = 32768, m_pend_i = 32768, m_act_n = 32768, m_act_i = 32768;
    int hit_hi = 0, hit_lo = 0, wraps = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int scale(input int s, input int g);
        longint p;
        p = longint'(s) * longint'(g);
        return int'(p >>> 15);
    endfunction

    function automatic int expect_mix(input int ns, input int is, input bit ien);
        int t;
        t = scale(ns, m_act_n) + (ien ? scale(is, m_act_i) : 0);
        if (t > 8191) t = 8191;
        if (t < -8192) t = -8192;
        return t;
    endfunction

    // one edge with optional tick/start; checks results at the next falling edge
    task automatic edge_step(input bit st, input bit tk, input string req);
        bit exp_s;
        int prev_n;
        start_cmd = st;
        smp_tick  = tk;
        exp_s = 1'b0;
        if (tk && m_run && !st) begin
            m_out = expect_mix(noise_val(m_naddr), intf_val(m_iaddr), intf_en);
            exp_s = 1'b1;
            if (m_out == 8191) hit_hi++;
            if (m_out == -8192) hit_lo++;
            prev_n = m_naddr;
            m_naddr = (m_naddr + 1) % ND;
            if (prev_n == ND - 1) wraps++;
            if (intf_en) m_iaddr = (m_iaddr + 1) % ID;
        end else if (tk) begin
            m_out = 0;
        end
        if (st) begin
            m_naddr = int'(ref_lfsr % 16'(ND));
            m_iaddr = 0;
            m_run = 1'b1;
        end
        if (tk) begin
            m_act_n = m_pend_n;
            m_act_i = m_pend_i;
        end
        @(negedge clk);
        smp_tick = 1'b0;
        start_cmd = 1'b0;
        check(req, "dac_word", int'($signed(dac_word)), m_out);
        check(req, "dac_stb", int'(dac_stb), int'(exp_s));
        check(req, "noise_addr", int'(noise_addr), m_naddr);
        check(req, "intf_addr", int'(intf_addr), m_iaddr);
    endtask

    task automatic write_gain(input bit sel, input int val);
        wr_en = 1'b1; wr_sel = sel; wr_gain = 16'(val);
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) m_pend_i = val; else m_pend_n = val;
    endtask

    task automatic t_reset;
        check("R1", "dac_word", int'(dac_word), 0);
        check("R1", "dac_stb", int'(dac_stb), 0);
        check("R1", "noise_addr", int'(noise_addr), 0);
        check("R1", "intf_addr", int'(intf_addr), 0);
    endtask

    task automatic t_idle;
        edge_step(1'b0, 1'b1, "R10 idle tick");
    endtask

    task automatic t_start;
        repeat (7) @(negedge clk);
        edge_step(1'b1, 1'b0, "R2 start");
    endtask

    task automatic t_unity;
        intf_en = 1'b0;
        for (int k = 0; k < 8; k++) edge_step(1'b0, 1'b1, "R4 unity");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R6", "intf_addr held", int'(intf_addr), 0);
        end
    endtask

    task automatic t_half;
        write_gain(1'b0, 16'h4000);
        edge_step(1'b0, 1'b1, "R9 old weight");
        for (int k = 0; k < 6; k++) edge_step(1'b0, 1'b1, "R4 half");
    endtask

    task automatic t_shadow;
        write_gain(1'b0, 16'h2000);
        @(negedge clk);
        write_gain(1'b0, 16'h6000);
        edge_step(1'b0, 1'b1, "R9 commit");
        edge_step(1'b0, 1'b1, "R9 last write wins");
        edge_step(1'b0, 1'b1, "R9 steady");
    endtask

    task automatic t_intf;
        write_gain(1'b1, 16'h3000);
        intf_en = 1'b1;
        for (int k = 0; k < 20; k++) edge_step(1'b0, 1'b1, "R5 mix");
        check("R8", "intf wrap seen", int'(m_iaddr < 20), 1);
        intf_en = 1'b0;
        for (int k = 0; k < 4; k++) edge_step(1'b0, 1'b1, "R6 intf off");
    endtask

    task automatic t_sat;
        write_gain(1'b0, 16'hFFFF);
        write_gain(1'b1, 16'hFFFF);
        intf_en = 1'b1;
        hit_hi = 0; hit_lo = 0;
        for (int k = 0; k < 40; k++) edge_step(1'b0, 1'b1, "R7 sat");
        check("R7", "positive clip seen", int'(hit_hi > 0), 1);
        check("R7", "negative clip seen", int'(hit_lo > 0), 1);
        intf_en = 1'b0;
        write_gain(1'b0, 16'h8000);
        edge_step(1'b0, 1'b1, "R7 restore");
    endtask

    task automatic t_wrap;
        wraps = 0;
        for (int k = 0; k < ND + 4; k++) edge_step(1'b0, 1'b1, "R8 wrap");
        check("R8", "noise wrap seen", int'(wraps > 0), 1);
    endtask

    task automatic t_restart;
        intf_en = 1'b1;
        edge_step(1'b0, 1'b1, "R11 pre");
        edge_step(1'b1, 1'b1, "R11 start beats tick");
        edge_step(1'b0, 1'b1, "R11 after restart");
        intf_en = 1'b0;
    endtask

    task automatic t_stop;
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
        m_run = 1'b0;
        edge_step(1'b0, 1'b1, "R10 stopped tick");
        edge_step(1'b0, 1'b1, "R10 stopped tick 2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_idle;
        t_start;
        t_unity;
        t_half;
        t_shadow;
        t_intf;
        t_sat;
        t_wrap;
        t_restart;
        t_stop;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule